// File: doc/BRIEF.md
# Eight-Lane Double-Edge Hit Frame Serializer

This block moves a binary hit image off the chip. The image holds one bit per pixel. When the trigger logic asks for a load, the block copies the whole image in one clock cycle into its own shift storage. The pixel hit flops can then start collecting the next event while the earlier image drains out.

The image is cut into eight lanes. Each lane owns a contiguous block of pixel rows. Every lane presents two bits per clock cycle: one while the clock is high and one while it is low. A frame strobe line stays high for the whole time that frame data is on the lanes. A busy flag tells the trigger logic when a new load would be refused. A request that arrives while busy is dropped and reported with a one-cycle reject pulse.

The pixel index is `row * COLS + col`. Lane `L` carries pixels `L*BPL` up to `L*BPL + BPL - 1`, where `BPL = ROWS*COLS/8`. `ROWS` must be a multiple of the lane count, and `BPL` must be even. One frame occupies `BPL/2` clock cycles.

Top module: `hfr_readout`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `frame_strobe` and `load_reject` are 0 and every lane drives 0 in both clock phases.
- R2: A `load_req` sampled high on a rising edge while `busy` is low is accepted. From that edge on, `busy` and `frame_strobe` are 1.
- R3: After an accepted load, `busy` and `frame_strobe` stay 1 for exactly `BPL/2` cycles and then both return to 0. A request in the following cycle is accepted again, so frames can repeat every `BPL/2 + 1` cycles.
- R4: In cycle k of a frame (k = 0 at the accepting edge), lane L outputs pixel `L*BPL + 2k` while the clock is high and pixel `L*BPL + 2k + 1` while the clock is low. Lane L is `lane_out[L]`.
- R5: The frame sent is the `hit_frame` value sampled at the accepting edge. Later changes of `hit_frame` do not alter it.
- R6: A `load_req` sampled high while `busy` is 1 is ignored. It gives a 1 on `load_reject` for the next cycle and leaves the frame in progress unchanged. This also applies in the last cycle of a frame.
- R7: While `busy` is 0, all lanes drive 0 in both clock phases, whatever `hit_frame` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both phases carry lane data |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Request to snapshot `hit_frame` |
| hit_frame | input | ROWS*COLS | Pixel hit bits, bit index = row*COLS+col |
| busy | output | 1 | Frame in progress; loads are refused |
| frame_strobe | output | 1 | High for the whole duration of frame data |
| load_reject | output | 1 | One-cycle pulse after a refused request |
| lane_out | output | 8 | Double-edge serial data, one bit per lane |

## Verification
Let E0 be the rising edge that accepts a load. `busy` and `frame_strobe` are high from E0 on. Bits 2k and 2k+1 are due in the high phase and in the low phase that follow edge Ek. Both flags drop after edge E(BPL/2). A refused request sampled at edge En shows on `load_reject` in the cycle after En. The bench drives inputs 2 ns after a rising edge and samples 5 ns after it (high phase) and 15 ns after it (low phase). Every expected value is therefore taken in the phase where the requirement places it, away from any edge. The random frames and random reject positions include a refused request in the very last frame cycle. They also include back-to-back frames spaced one idle cycle apart.

// File: rtl/hfr_pkg.sv
`timescale 1ns/1ps
package hfr_pkg;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_SHIFT = 1'b1
    } rd_state_e;

    // Command shared by all lane shifters
    typedef struct packed {
        logic load;
        logic shift;
    } lane_cmd_t;

    function automatic int unsigned lane_bits(int unsigned rows, int unsigned cols,
                                              int unsigned lanes);
        return (rows * cols) / lanes;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hfr_ctrl.sv
`timescale 1ns/1ps
module hfr_ctrl
    import hfr_pkg::*;
#(
    parameter int unsigned CYC = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load_req,
    output lane_cmd_t cmd,
    output logic      busy,
    output logic      strobe,
    output logic      reject
);
    localparam int unsigned CW = cnt_width(CYC);

    rd_state_e       state;
    logic [CW-1:0]   cnt;
    logic            accept;
    logic            last;

    always_comb begin
        accept    = load_req && (state == RD_IDLE);
        last      = (cnt == CW'(CYC - 1));
        busy      = (state == RD_SHIFT);
        cmd.load  = accept;
        cmd.shift = (state == RD_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RD_IDLE;
            cnt    <= '0;
            strobe <= 1'b0;
            reject <= 1'b0;
        end else begin
            reject <= load_req && (state == RD_SHIFT);
            case (state)
                RD_IDLE: begin
                    if (accept) begin
                        state  <= RD_SHIFT;
                        cnt    <= '0;
                        strobe <= 1'b1;
                    end
                end
                default: begin
                    if (last) begin
                        state  <= RD_IDLE;
                        strobe <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/hfr_lane.sv
`timescale 1ns/1ps
module hfr_lane
    import hfr_pkg::*;
#(
    parameter int unsigned BPL = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  lane_cmd_t      cmd,
    input  logic [BPL-1:0] din,
    output logic           q
);
    logic [BPL-1:0] sr;

    // sr[0] holds the high-phase bit, sr[1] the low-phase bit
    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (cmd.load) begin
            sr <= din;
        end else if (cmd.shift) begin
            sr <= sr >> 2;
        end
    end

    // Double-edge output: clock level picks one of the two registered bits
    always_comb begin
        q = clk ? sr[0] : sr[1];
    end

endmodule

// File: rtl/hfr_readout.sv
`timescale 1ns/1ps
module hfr_readout
    import hfr_pkg::*;
#(
    parameter int unsigned ROWS  = 16,
    parameter int unsigned COLS  = 4,
    parameter int unsigned LANES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_req,
    input  logic [ROWS*COLS-1:0]   hit_frame,
    output logic                   busy,
    output logic                   frame_strobe,
    output logic                   load_reject,
    output logic [LANES-1:0]       lane_out
);
    localparam int unsigned PIX = ROWS * COLS;
    localparam int unsigned BPL = lane_bits(ROWS, COLS, LANES);
    localparam int unsigned CYC = BPL / 2;

    lane_cmd_t cmd;

    hfr_ctrl #(.CYC(CYC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load_req (load_req),
        .cmd      (cmd),
        .busy     (busy),
        .strobe   (frame_strobe),
        .reject   (load_reject)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hfr_lane #(.BPL(BPL)) u_lane (
            .clk (clk),
            .rst (rst),
            .cmd (cmd),
            .din (hit_frame[g*BPL +: BPL]),
            .q   (lane_out[g])
        );
    end

endmodule

// File: rtl/hfr_readout_chk.sv
`timescale 1ns/1ps
module hfr_readout_chk #(
    parameter int unsigned CYC   = 4,
    parameter int unsigned LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             load_req,
    input logic             busy,
    input logic             strobe,
    input logic             reject,
    input logic [LANES-1:0] lanes
);
    localparam int unsigned RW = $clog2(CYC + 2) + 1;

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)       run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!busy && !strobe && !reject));

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (load_req && !busy) |=> (busy && strobe));

    p_strobe_busy_r3: assert property (@(posedge clk) disable iff (rst)
        strobe == busy);

    p_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == RW'(CYC)));

    p_bound_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < RW'(CYC)));

    p_reject_r6: assert property (@(posedge clk) disable iff (rst)
        reject |-> $past(busy && load_req));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lanes == '0));

endmodule

bind hfr_readout hfr_readout_chk #(.CYC(CYC), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_req (load_req),
    .busy     (busy),
    .strobe   (frame_strobe),
    .reject   (load_reject),
    .lanes    (lane_out)
);

// File: tb/hfr_readout_bench.sv
`timescale 1ns/1ps
module hfr_readout_bench;
    localparam int ROWS  = 16;
    localparam int COLS  = 4;
    localparam int LANES = 8;
    localparam int PIX   = ROWS * COLS;
    localparam int BPL   = PIX / LANES;
    localparam int CYC   = BPL / 2;

    logic             clk = 1'b0;
    logic             rst;
    logic             load_req;
    logic [PIX-1:0]   hit_frame;
    logic             busy;
    logic             frame_strobe;
    logic             load_reject;
    logic [LANES-1:0] lane_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int seed_v;

    always #10 clk = ~clk;

    hfr_readout #(.ROWS(ROWS), .COLS(COLS), .LANES(LANES)) u_hfr_readout (
        .clk          (clk),
        .rst          (rst),
        .load_req     (load_req),
        .hit_frame    (hit_frame),
        .busy         (busy),
        .frame_strobe (frame_strobe),
        .load_reject  (load_reject),
        .lane_out     (lane_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [LANES-1:0] exp_lanes(input logic [PIX-1:0] f, input int j);
        logic [LANES-1:0] r;
        for (int l = 0; l < LANES; l++) r[l] = f[l*BPL + j];
        return r;
    endfunction

    function automatic logic [PIX-1:0] rnd_frame();
        return {$urandom, $urandom};
    endfunction

    // Called between edges; the next rising edge accepts the load (R2)
    task automatic run_frame(input logic [PIX-1:0] f, input int rej_at);
        load_req  = 1'b1;
        hit_frame = f;
        for (int k = 0; k <= CYC; k++) begin
            @(posedge clk); #2;
            if (k == 0) begin
                load_req  = 1'b0;
                hit_frame = ~f;                // R5: changes after capture
            end
            if (k == rej_at) begin
                load_req  = 1'b1;              // R6: request while busy
                hit_frame = rnd_frame();
            end
            if (k == rej_at + 1) load_req = 1'b0;
            #3;
            check("R6 reject", load_reject, (rej_at >= 0 && k == rej_at + 1));
            if (k < CYC) begin
                check("R2 busy", busy, 1);
                check("R3 strobe", frame_strobe, 1);
                check("R4 high phase", lane_out, exp_lanes(f, 2*k));
            end else begin
                check("R3 busy end", busy, 0);
                check("R3 strobe end", frame_strobe, 0);
                check("R7 idle high", lane_out, 0);
            end
            #10;
            if (k < CYC) check("R4 low phase", lane_out, exp_lanes(f, 2*k + 1));
            else         check("R7 idle low", lane_out, 0);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            load_req  = 1'b0;
            hit_frame = rnd_frame();
            #3;
            check("R7 busy idle", busy, 0);
            check("R7 lanes high idle", lane_out, 0);
            #10;
            check("R7 lanes low idle", lane_out, 0);
        end
    endtask

    initial begin
        seed_v    = $urandom(32'd5150);
        rst       = 1'b1;
        load_req  = 1'b0;
        hit_frame = '0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #2;
            hit_frame = rnd_frame();
            #3;
            check("R1 busy", busy, 0);
            check("R1 strobe", frame_strobe, 0);
            check("R1 reject", load_reject, 0);
            check("R1 lanes high", lane_out, 0);
            #10;
            check("R1 lanes low", lane_out, 0);
        end
        @(posedge clk); #2;
        rst = 1'b0;
        #3;
        check("R1 busy after release", busy, 0);
        check("R1 lanes after release", lane_out, 0);
        #10;

        // Directed patterns
        run_frame({PIX{1'b1}}, -1);
        run_frame({(PIX/2){2'b01}}, -1);
        run_frame(64'h1 << BPL, 0);                 // first pixel of lane 1
        run_frame(64'h1 << (BPL - 1), CYC - 1);     // last pixel of lane 0, late reject
        run_frame('0, 1);
        idle_cycles(3);
        // Back-to-back frames (R3)
        run_frame(64'hDEAD_BEEF_0123_4567, -1);
        run_frame(64'h8000_0000_0000_0001, CYC - 1);
        run_frame(64'hF0F0_0F0F_AA55_33CC, -1);

        // Random frames with random reject positions
        for (int n = 0; n < 40; n++) begin
            run_frame(rnd_frame(), int'($urandom % (CYC + 1)) - 1);
            if ((n % 7) == 3) idle_cycles(1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule